// File: doc/BRIEF.md
# SPI Clock Divider and Periodic Timer

This block owns one down-counting reload counter that runs on the system clock and serves two purposes. While the serial interface is enabled as a master and a transfer is in progress, every expiry of the counter flips the serial clock line and emits a one-cycle strobe that a shifter can use to move data. While the interface is disabled and the timer bit is set, the same counter instead fires a sticky interrupt flag each time it expires. That makes it a general-purpose periodic timer.

Software reaches the block through a byte-wide write port. The reload value is written as two bytes. Writing the high byte only stages it. Writing the low byte commits both bytes to the active reload register. A reload value of zero stands for 65536, which gives the slowest serial clock (system clock divided by 131072) or the longest timer period. A new reload value never disturbs a countdown that has already started; it is picked up at the next expiry.

Behaviour is organised around three states:
- **IDLE**: the counter is held at the reload value and the serial clock sits at the idle polarity.
- **SHIFT**: the master divider is running.
- **TIMER**: the periodic timer is running.

There are four transitions:
- **START** (IDLE to SHIFT): interface enabled and a transfer active.
- **STOP** (SHIFT to IDLE): the transfer ends or the interface is disabled.
- **ARM** (IDLE to TIMER): interface disabled with the timer bit set.
- **DISARM** (TIMER to IDLE): the interface is enabled or the timer bit is cleared.

The state follows the control register one cycle after it is written.

Top module: `spi_clkdiv_timer`

## Requirements
- R1: Synchronous active-high reset drives `sck`, `sck_tog` and `tmr_irq` low and clears the reload value, the staged byte, the control bits and the counter.
- R2: With control bit 0 (interface enable) set and `xfer_active` high, `sck` inverts every N system clocks, where N is the committed reload value. The resulting serial clock is the system clock divided by 2N. `sck_tog` is high for exactly the one cycle in which `sck` takes its new level.
- R3: Whenever the block is not shifting (no transfer active, or the interface is disabled), `sck` equals control bit 2 (idle polarity) and `sck_tog` stays low.
- R4: A committed reload value of 0 counts 65536 system clocks per expiry. The first expiry comes 65536 cycles after the counter starts, which is two cycles after the control write that arms it.
- R5: With control bit 0 clear and control bit 1 (timer control) set, `tmr_irq` is set once every N system clocks.
- R6: With control bit 1 clear, or with control bit 0 set, no timer expiry ever sets `tmr_irq`.
- R7: `tmr_irq` is a level. It stays set until a write to address 3 with data bit 0 set clears it. A write to address 3 with bit 0 clear has no effect, and a new expiry in the same cycle as a clear wins.
- R8: A write to address 0 stages the high reload byte without changing the active value. A write to address 1 commits {staged high byte, written low byte}. A running countdown finishes with the value it started with, and the new value applies from the next expiry.
- R9: Address 2 holds the control bits: bit 0 is interface enable, bit 1 is timer control, bit 2 is idle polarity. The mode follows this register one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 high byte, 1 low byte and commit, 2 control, 3 status clear |
| wr_data | input | 8 | Register write data |
| xfer_active | input | 1 | High while a master transfer is in progress |
| sck | output | 1 | Serial clock level |
| sck_tog | output | 1 | One-cycle strobe on each serial clock change |
| tmr_irq | output | 1 | Sticky timer interrupt level |

## Verification
The hardest situation to reach is a reload write that arrives partway through a countdown. The point to prove is that the interval already under way keeps its old length and only the following one takes the new value. The stimulus lets the divider run at a short period, then commits a longer reload at a cycle that is not aligned to an expiry. It then checks the spacing of the strobe just before the write, the spacing just after it, and the interval after that. A second hard spot is the 65536-count case. This is reached straight out of reset by arming the timer without writing any reload, and the bench measures the arm-to-interrupt distance.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_TIMER = 2'd2
    } sdt_state_e;

    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_TMR_BIT = 1;
    localparam int CTL_POL_BIT = 2;
    localparam int CTL_W       = 3;
    localparam int STS_CLR_BIT = 0;

endpackage

// File: rtl/sdt_regs.sv
module sdt_regs
    import sdt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [$clog2(LANES+2)-1:0]    wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    output logic [BYTE_W*LANES-1:0]       reload,
    output logic                          iface_en,
    output logic                          tmr_ctl,
    output logic                          idle_pol,
    output logic                          irq_clr
);

    localparam int CNT_W       = BYTE_W * LANES;
    localparam int AW          = $clog2(LANES + 2);
    localparam int ADDR_COMMIT = LANES - 1;
    localparam int ADDR_CTL    = LANES;
    localparam int ADDR_STS    = LANES + 1;

    logic [CNT_W-1:0] commit_word;
    logic [CNT_W-1:0] reload_q;
    logic [CTL_W-1:0] ctl_q;

    // Upper byte lanes are staged; the lowest lane comes straight from the bus.
    for (genvar i = 1; i < LANES; i++) begin : g_lane
        logic [BYTE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (wr_en && (wr_addr == AW'(LANES - 1 - i))) begin
                byte_q <= wr_data;
            end
        end
        assign commit_word[i*BYTE_W +: BYTE_W] = byte_q;
    end
    assign commit_word[BYTE_W-1:0] = wr_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
        end else if (wr_en && (wr_addr == AW'(ADDR_COMMIT))) begin
            reload_q <= commit_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (wr_en && (wr_addr == AW'(ADDR_CTL))) begin
            ctl_q <= wr_data[CTL_W-1:0];
        end
    end

    assign reload   = reload_q;
    assign iface_en = ctl_q[CTL_EN_BIT];
    assign tmr_ctl  = ctl_q[CTL_TMR_BIT];
    assign idle_pol = ctl_q[CTL_POL_BIT];
    assign irq_clr  = wr_en && (wr_addr == AW'(ADDR_STS)) && wr_data[STS_CLR_BIT];

endmodule

// File: rtl/sdt_mode_fsm.sv
module sdt_mode_fsm
    import sdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       iface_en,
    input  logic       tmr_ctl,
    input  logic       xfer_active,
    output sdt_state_e state
);

    sdt_state_e state_q;
    sdt_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (iface_en && xfer_active) begin
                    state_d = ST_SHIFT;            // START
                end else if (!iface_en && tmr_ctl) begin
                    state_d = ST_TIMER;            // ARM
                end
            end
            ST_SHIFT: begin
                if (!(iface_en && xfer_active)) begin
                    state_d = ST_IDLE;             // STOP
                end
            end
            ST_TIMER: begin
                if (iface_en || !tmr_ctl) begin
                    state_d = ST_IDLE;             // DISARM
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    AST_SHIFT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |-> $past(iface_en)); // R9

    AST_TIMER_NEEDS_DIS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TIMER) |-> !$past(iface_en)); // R6

endmodule

// File: rtl/sdt_count.sv
module sdt_count
    import sdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  sdt_state_e       state,
    input  logic [CNT_W-1:0] reload,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             running;

    assign running = (state != ST_IDLE);
    assign expire  = running && (cnt_q == ONE);

    // A loaded zero wraps through all ones, giving a full 2^CNT_W count.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (state)
                ST_SHIFT, ST_TIMER: begin
                    if (cnt_q == ONE) begin
                        cnt_q <= reload;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: cnt_q <= reload;
            endcase
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> (cnt_q == $past(reload))); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (running && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE)); // R2

    AST_EXPIRY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == $past(reload))); // R8

endmodule

// File: rtl/sdt_outs.sv
module sdt_outs
    import sdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sdt_state_e state,
    input  logic       expire,
    input  logic       idle_pol,
    input  logic       irq_clr,
    output logic       sck,
    output logic       sck_tog,
    output logic       irq
);

    logic sck_q;
    logic tog_q;
    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            tog_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            tog_q <= (state == ST_SHIFT) && expire;
            unique case (state)
                ST_SHIFT: sck_q <= expire ? ~sck_q : sck_q;
                default:  sck_q <= idle_pol;
            endcase
            if ((state == ST_TIMER) && expire) begin
                irq_q <= 1'b1;
            end else if (irq_clr) begin
                irq_q <= 1'b0;
            end
        end
    end

    assign sck     = sck_q;
    assign sck_tog = tog_q;
    assign irq     = irq_q;

    AST_STROBE_EDGE: assert property (@(posedge clk) disable iff (rst)
        tog_q |-> (sck_q != $past(sck_q))); // R2

    AST_TOG_SHIFT: assert property (@(posedge clk) disable iff (rst)
        tog_q |-> ($past(state) == ST_SHIFT)); // R3

    AST_SCK_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |=> (sck_q == $past(idle_pol))); // R3

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !irq_clr) |=> irq_q); // R7

    AST_IRQ_TIMER_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(state) == ST_TIMER)); // R6

endmodule

// File: rtl/spi_clkdiv_timer.sv
module spi_clkdiv_timer
    import sdt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(LANES+2)-1:0] wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic                       xfer_active,
    output logic                       sck,
    output logic                       sck_tog,
    output logic                       tmr_irq
);

    localparam int CNT_W = BYTE_W * LANES;

    logic [CNT_W-1:0] reload;
    logic             iface_en;
    logic             tmr_ctl;
    logic             idle_pol;
    logic             irq_clr;
    logic             expire;
    sdt_state_e       state;

    sdt_regs #(.BYTE_W(BYTE_W), .LANES(LANES)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reload   (reload),
        .iface_en (iface_en),
        .tmr_ctl  (tmr_ctl),
        .idle_pol (idle_pol),
        .irq_clr  (irq_clr)
    );

    sdt_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .iface_en    (iface_en),
        .tmr_ctl     (tmr_ctl),
        .xfer_active (xfer_active),
        .state       (state)
    );

    sdt_count #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .reload (reload),
        .expire (expire)
    );

    sdt_outs u_outs (
        .clk      (clk),
        .rst      (rst),
        .state    (state),
        .expire   (expire),
        .idle_pol (idle_pol),
        .irq_clr  (irq_clr),
        .sck      (sck),
        .sck_tog  (sck_tog),
        .irq      (tmr_irq)
    );

endmodule

// File: tb/tb_spi_clkdiv_timer.sv
module tb_spi_clkdiv_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       xfer_active = 1'b0;
    logic       sck, sck_tog, tmr_irq;

    always #4 clk = ~clk;   // 125 MHz

    spi_clkdiv_timer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .xfer_active(xfer_active), .sck(sck), .sck_tog(sck_tog), .tmr_irq(tmr_irq)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Behavioural reference: remaining cycles to next expiry as a plain integer.
    int m_en, m_tc, m_pol, m_hi, m_rel, m_rem, m_mode, m_sck, m_tog, m_irq;
    int m_ev, m_len, m_clr;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_en = 0; m_tc = 0; m_pol = 0; m_hi = 0; m_rel = 0;
            m_rem = 65536; m_mode = 0; m_sck = 0; m_tog = 0; m_irq = 0;
        end else begin
            m_len = (m_rel == 0) ? 65536 : m_rel;
            m_ev = 0;
            m_clr = (wr_en && wr_addr == 2'd3 && wr_data[0]) ? 1 : 0;
            if (m_mode != 0) begin
                if (m_rem == 1) begin m_ev = 1; m_rem = m_len; end
                else m_rem = m_rem - 1;
            end else begin
                m_rem = m_len;
            end
            m_tog = (m_mode == 1 && m_ev == 1) ? 1 : 0;
            if (m_mode == 1) begin
                if (m_ev == 1) m_sck = 1 - m_sck;
            end else begin
                m_sck = m_pol;
            end
            if (m_mode == 2 && m_ev == 1) m_irq = 1;
            else if (m_clr == 1) m_irq = 0;
            case (m_mode)
                0: if (m_en == 1 && xfer_active) m_mode = 1;
                   else if (m_en == 0 && m_tc == 1) m_mode = 2;
                1: if (!(m_en == 1 && xfer_active)) m_mode = 0;
                default: if (m_en == 1 || m_tc == 0) m_mode = 0;
            endcase
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_hi = wr_data;
                    2'd1: m_rel = m_hi * 256 + wr_data;
                    2'd2: begin m_en = wr_data[0]; m_tc = wr_data[1]; m_pol = wr_data[2]; end
                    default: ;
                endcase
            end
        end
    end

    int tog_log[$];
    int irq_log[$];
    logic irq_d = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            chk({cur_req, " sck"}, int'(sck), m_sck);
            chk({cur_req, " sck_tog"}, int'(sck_tog), m_tog);
            chk({cur_req, " tmr_irq"}, int'(tmr_irq), m_irq);
            if (sck_tog) tog_log.push_back(cyc);
            if (tmr_irq && !irq_d) irq_log.push_back(cyc);
        end
        irq_d = tmr_irq;
    end

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: act=timeout exp=finish");
        finish_run();
    end

    initial begin
        int acyc, we, j;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sck", int'(sck), 0);
        chk("R1 tog", int'(sck_tog), 0);
        chk("R1 irq", int'(tmr_irq), 0);

        // R1/R4: reload cleared by reset means 65536; arm the timer directly.
        cur_req = "R4";
        irq_log.delete();
        acyc = cyc;
        wr(2, 2);
        while (!tmr_irq) @(negedge clk);
        @(negedge clk);
        chk("R4 first expiry distance", irq_log[0] - acyc, 65538);
        wr(2, 0);
        wr(3, 1);
        chk("R7 cleared", int'(tmr_irq), 0);

        // R2: master divider with N=3
        cur_req = "R2";
        wr(0, 0); wr(1, 3); wr(2, 1);
        tog_log.delete();
        xfer_active = 1'b1;
        repeat (40) @(negedge clk);
        xfer_active = 1'b0;
        chk("R2 strobe count", (tog_log.size() >= 10) ? 1 : 0, 1);
        for (int k = 1; k < tog_log.size(); k++)
            chk("R2 toggle spacing", tog_log[k] - tog_log[k-1], 3);

        // R3: idle levels
        cur_req = "R3";
        repeat (4) @(negedge clk);
        tog_log.delete();
        chk("R3 idle low", int'(sck), 0);
        wr(2, 5);
        repeat (3) @(negedge clk);
        chk("R3 idle high", int'(sck), 1);
        chk("R3 no strobe", tog_log.size(), 0);

        // R8: commit mid-count
        cur_req = "R8";
        wr(2, 1);
        xfer_active = 1'b1;
        repeat (10) @(negedge clk);
        tog_log.delete();
        repeat (5) @(negedge clk);
        we = cyc + 1;
        wr(1, 7);
        repeat (30) @(negedge clk);
        j = 0;
        while (j < tog_log.size() && tog_log[j] <= we) j++;
        chk("R8 index valid", (j >= 1 && j + 1 < tog_log.size()) ? 1 : 0, 1);
        if (j >= 1 && j + 1 < tog_log.size()) begin
            chk("R8 interval in flight", tog_log[j] - tog_log[j-1], 3);
            chk("R8 interval after", tog_log[j+1] - tog_log[j], 7);
        end
        wr(0, 1);
        tog_log.delete();
        repeat (30) @(negedge clk);
        for (int k = 1; k < tog_log.size(); k++)
            chk("R8 staged byte inert", tog_log[k] - tog_log[k-1], 7);
        xfer_active = 1'b0;
        wr(0, 0); wr(1, 5);

        // R5: timer period 5 with clears
        cur_req = "R5";
        wr(2, 2);
        irq_log.delete();
        for (int n = 0; n < 4; n++) begin
            while (!tmr_irq) @(negedge clk);
            wr(3, 1);
        end
        @(negedge clk);
        for (int k = 1; k < irq_log.size(); k++)
            chk("R5 irq period", irq_log[k] - irq_log[k-1], 5);

        // R7: sticky level and clear semantics
        cur_req = "R7";
        while (!tmr_irq) @(negedge clk);
        wr(2, 0);
        repeat (12) @(negedge clk);
        chk("R7 held", int'(tmr_irq), 1);
        wr(3, 0);
        chk("R7 zero write inert", int'(tmr_irq), 1);
        wr(3, 1);
        chk("R7 one clears", int'(tmr_irq), 0);

        // R6: timer suppressed
        cur_req = "R6";
        irq_log.delete();
        repeat (30) @(negedge clk);
        chk("R6 tmr bit clear", int'(tmr_irq), 0);
        wr(2, 3);
        repeat (30) @(negedge clk);
        chk("R6 iface enabled", int'(tmr_irq), 0);
        chk("R6 no rises", irq_log.size(), 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule